// File: doc/BRIEF.md
# Counter Output Controller

This block drives two outputs that belong to one counter channel. The first output goes to a physical pin. The second is a virtual output that other logic can observe. Each output has two possible functions. It can follow a software set bit behind its own enable bit. It can also show the result of comparing the live counter value with a reference value stored for that output.

Software selects the function of each output and loads the two reference values through strobe bits in a process-output word. The mode pair is captured only on a rising edge of its strobe. Each reference value is captured from a 32-bit data field only on a rising edge of its own strobe. Holding a strobe high never reloads anything, so the rest of the word can change freely between loads. The counter that supplies the live value sits outside this block.

Top module: `cnt_out_ctrl`

## Requirements
- R1: A synchronous active-high reset drives both outputs low. It sets both modes to manual (code 00) and clears both reference values to zero.
- R2: In manual mode (code 00) with the enable bit high, each output follows its set bit. The change appears one clock edge after the set bit is sampled.
- R3: In manual mode with the enable bit low, the output stays low whatever the set bit is.
- R4: In mode code 01 the output is high when the count is greater than or equal to its reference. Both are compared as unsigned numbers.
- R5: In mode code 10 the output is high when the count is less than or equal to its reference. Both are compared as unsigned numbers.
- R6: In mode code 11 the output is high for exactly one clock after the first cycle in which the count equals the reference. It stays low while the equality persists, and it pulses again after the equality breaks and returns.
- R7: Both mode fields are captured together, only on a rising edge of the mode strobe. A mode field that changes while the strobe stays low or stays high has no effect.
- R8: Reference 1 and reference 2 are each captured from the data field on a rising edge of their own strobe. Holding that strobe high does not reload the reference.
- R9: The physical output uses mode field 1, reference 1, set bit 1 and enable bit 1. The virtual output uses mode field 2, reference 2, set bit 2 and enable bit 2. The two outputs are independent.
- R10: A mode or reference change reaches the output on the second clock edge after the strobe's rising edge is applied. On the first edge the output is still computed with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_mode | input | 1 | Strobe; a rising edge captures both mode fields |
| mode_phys | input | 2 | Mode field for the physical output |
| mode_virt | input | 2 | Mode field for the virtual output |
| load_ref1 | input | 1 | Strobe; a rising edge captures data_in as reference 1 |
| load_ref2 | input | 1 | Strobe; a rising edge captures data_in as reference 2 |
| data_in | input | CNT_W | Reference value data field |
| man_en_phys | input | 1 | Manual enable for the physical output |
| man_set_phys | input | 1 | Manual set bit for the physical output |
| man_en_virt | input | 1 | Manual enable for the virtual output |
| man_set_virt | input | 1 | Manual set bit for the virtual output |
| count_in | input | CNT_W | Live counter value |
| out_phys | output | 1 | Physical output |
| out_virt | output | 1 | Virtual output |

## Verification
The hardest case to reach is the match-pulse mode. There the output depends on the previous cycle's equality and on a reference that was loaded earlier by a separate strobe. So one pulse needs a reference load, a mode load and then a count sequence that leaves the match and returns to it. The stimulus table loads both references first, switches both outputs to the pulse mode and then walks the count through the values hit, hold, the other reference, and hit again. The strobes are also held high across rows while the data and mode fields change, to show that nothing reloads.

// File: rtl/cnt_out_pkg.sv
package cnt_out_pkg;

    localparam int MODE_W = 2;
    localparam int NUM_CH = 2;

    typedef enum logic [MODE_W-1:0] {
        OM_MANUAL      = 2'b00,
        OM_AT_LEAST    = 2'b01,
        OM_AT_MOST     = 2'b10,
        OM_MATCH_PULSE = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic en;
        logic set;
    } man_ctl_t;

    typedef struct packed {
        logic ge;
        logic le;
        logic eq;
    } cmp_res_t;

    function automatic logic select_output(
        input out_mode_e mode,
        input man_ctl_t  man,
        input cmp_res_t  cmp,
        input logic      eq_prev
    );
        logic r;
        case (mode)
            OM_MANUAL:      r = man.en & man.set;
            OM_AT_LEAST:    r = cmp.ge;
            OM_AT_MOST:     r = cmp.le;
            OM_MATCH_PULSE: r = cmp.eq & ~eq_prev;
            default:        r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strobe_latch.sv
module strobe_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_q;
    logic take;

    assign take = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (take) q <= d;
        end
    end

    // R7 / R8: a strobe that was already high does not reload
    a_r8_no_reload_on_hold: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> $stable(q));

    // R8: a rising edge captures the data presented with it
    a_r8_capture_on_edge: assert property (@(posedge clk) disable iff (rst)
        (strobe && !strobe_q) |=> (q == $past(d)));

endmodule

// File: rtl/out_channel.sv
module out_channel
    import cnt_out_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  out_mode_e        mode,
    input  man_ctl_t         man,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] ref_val,
    output logic             out
);
    cmp_res_t cmp;
    logic     eq_q;
    logic     out_d;

    always_comb begin
        cmp.ge = (count >= ref_val);
        cmp.le = (count <= ref_val);
        cmp.eq = (count == ref_val);
        out_d  = select_output(mode, man, cmp, eq_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q <= 1'b0;
            out  <= 1'b0;
        end else begin
            eq_q <= cmp.eq;
            out  <= out_d;
        end
    end

    // R3: manual mode without enable keeps the output low
    a_r3_disabled_low: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_MANUAL && !man.en) |=> !out);

    // R4: at-least mode is high when the count reaches the reference
    a_r4_at_least: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_AT_LEAST && count >= ref_val) |=> out);

    // R5: at-most mode is low when the count exceeds the reference
    a_r5_at_most_low: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_AT_MOST && count > ref_val) |=> !out);

    // R6: no second pulse while the match continues
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (mode == OM_MATCH_PULSE && eq_q) |=> !out);

endmodule

// File: rtl/cnt_out_ctrl.sv
module cnt_out_ctrl
    import cnt_out_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_mode,
    input  logic [1:0]       mode_phys,
    input  logic [1:0]       mode_virt,
    input  logic             load_ref1,
    input  logic             load_ref2,
    input  logic [CNT_W-1:0] data_in,
    input  logic             man_en_phys,
    input  logic             man_set_phys,
    input  logic             man_en_virt,
    input  logic             man_set_virt,
    input  logic [CNT_W-1:0] count_in,
    output logic             out_phys,
    output logic             out_virt
);
    localparam int MODES_W = NUM_CH * MODE_W;

    logic [MODES_W-1:0] mode_pair;
    logic [NUM_CH-1:0]  ref_load;
    logic [CNT_W-1:0]   ch_ref [NUM_CH];
    man_ctl_t           ch_man [NUM_CH];
    logic [NUM_CH-1:0]  ch_out;

    assign ref_load  = {load_ref2, load_ref1};
    assign ch_man[0] = '{en: man_en_phys, set: man_set_phys};
    assign ch_man[1] = '{en: man_en_virt, set: man_set_virt};

    // R7: both mode fields share one strobe
    strobe_latch #(.W(MODES_W)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .strobe (load_mode),
        .d      ({mode_virt, mode_phys}),
        .q      (mode_pair)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        strobe_latch #(.W(CNT_W)) u_ref (
            .clk    (clk),
            .rst    (rst),
            .strobe (ref_load[g]),
            .d      (data_in),
            .q      (ch_ref[g])
        );

        out_channel #(.CNT_W(CNT_W)) u_out (
            .clk     (clk),
            .rst     (rst),
            .mode    (out_mode_e'(mode_pair[g*MODE_W +: MODE_W])),
            .man     (ch_man[g]),
            .count   (count_in),
            .ref_val (ch_ref[g]),
            .out     (ch_out[g])
        );
    end

    assign out_phys = ch_out[0];
    assign out_virt = ch_out[1];

    // R1: outputs are low in the cycle after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> (!out_phys && !out_virt));

endmodule

// File: tb/cnt_out_ctrl_tb.sv
module cnt_out_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_mode, load_ref1, load_ref2;
    logic [1:0]  mode_phys, mode_virt;
    logic [31:0] data_in, count_in;
    logic        man_en_phys, man_set_phys, man_en_virt, man_set_virt;
    logic        out_phys, out_virt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cnt_out_ctrl #(.CNT_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .load_mode(load_mode), .mode_phys(mode_phys), .mode_virt(mode_virt),
        .load_ref1(load_ref1), .load_ref2(load_ref2), .data_in(data_in),
        .man_en_phys(man_en_phys), .man_set_phys(man_set_phys),
        .man_en_virt(man_en_virt), .man_set_virt(man_set_virt),
        .count_in(count_in), .out_phys(out_phys), .out_virt(out_virt)
    );

    typedef struct packed {
        logic        lm;
        logic [1:0]  ma;
        logic [1:0]  mb;
        logic        ea, sa, eb, sb;
        logic        l1, l2;
        logic [31:0] data;
        logic [31:0] cnt;
        logic        xa, xb;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    // lm ma mb ea sa eb sb l1 l2 data cnt xa xb req
    localparam vec_t TBL [NV] = '{
        '{1'b0,2'd0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,32'd0,  32'd0,  1'b1,1'b0,4'd2},  // R2
        '{1'b0,2'd0,2'd0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,32'd0,  32'd0,  1'b0,1'b1,4'd9},  // R9
        '{1'b0,2'd0,2'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,32'd0,  32'd0,  1'b0,1'b0,4'd3},  // R3
        '{1'b0,2'd1,2'd2,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,32'd100,32'd0,  1'b1,1'b0,4'd7},  // R7 mode w/o strobe
        '{1'b0,2'd1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,32'd7,  32'd0,  1'b0,1'b0,4'd8},  // R8 held
        '{1'b0,2'd1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,32'd50, 32'd0,  1'b0,1'b0,4'd8},  // R8 ref2
        '{1'b1,2'd1,2'd2,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd100,1'b0,1'b0,4'd10}, // R10 old mode
        '{1'b1,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd100,1'b1,1'b0,4'd4},  // R4 R7 held
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd99, 1'b0,1'b0,4'd4},  // R4
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd50, 1'b0,1'b1,4'd5},  // R5
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd0,  1'b0,1'b1,4'd5},  // R5
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'hFFFF_FFFF,1'b1,1'b0,4'd4}, // R4 unsigned
        '{1'b1,2'd3,2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd5,  1'b0,1'b1,4'd10}, // R10
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd100,1'b1,1'b0,4'd6},  // R6 hit
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd100,1'b0,1'b0,4'd6},  // R6 hold
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd50, 1'b0,1'b1,4'd6},  // R6 other
        '{1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,32'd0,  32'd100,1'b1,1'b0,4'd6},  // R6 re-hit
        '{1'b1,2'd0,2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'd0,  32'd0,  1'b0,1'b0,4'd10}, // R10
        '{1'b0,2'd0,2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,32'd0,  32'd0,  1'b1,1'b1,4'd2}   // R2
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        load_mode = 0; load_ref1 = 0; load_ref2 = 0;
        mode_phys = 0; mode_virt = 0; data_in = 0; count_in = 0;
        man_en_phys = 0; man_set_phys = 0; man_en_virt = 0; man_set_virt = 0;
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        step();
        step();
        check("R1", "out_phys in reset", out_phys, 1'b0);
        check("R1", "out_virt in reset", out_virt, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            load_mode    = TBL[i].lm;
            mode_phys    = TBL[i].ma;
            mode_virt    = TBL[i].mb;
            man_en_phys  = TBL[i].ea;
            man_set_phys = TBL[i].sa;
            man_en_virt  = TBL[i].eb;
            man_set_virt = TBL[i].sb;
            load_ref1    = TBL[i].l1;
            load_ref2    = TBL[i].l2;
            data_in      = TBL[i].data;
            count_in     = TBL[i].cnt;
            step();
            check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d out_phys", i), out_phys, TBL[i].xa);
            check($sformatf("R%0d", TBL[i].req), $sformatf("row %0d out_virt", i), out_virt, TBL[i].xb);
        end

        // R1: reset while manual set is active drives outputs low
        man_en_phys = 1; man_set_phys = 1; man_en_virt = 1; man_set_virt = 1;
        load_mode = 0;
        rst = 1'b1;
        step();
        check("R1", "out_phys during reset", out_phys, 1'b0);
        check("R1", "out_virt during reset", out_virt, 1'b0);
        rst = 1'b0;
        step();
        check("R1", "manual default phys", out_phys, 1'b1);
        check("R1", "manual default virt", out_virt, 1'b1);

        // R1: references are zero after reset
        load_mode = 1; mode_phys = 2'd2; mode_virt = 2'd1; count_in = 0;
        step();
        load_mode = 0;
        step();
        check("R1", "at-most vs zero ref, count 0", out_phys, 1'b1);
        check("R1", "at-least vs zero ref, count 0", out_virt, 1'b1);
        count_in = 1;
        step();
        check("R1", "at-most vs zero ref, count 1", out_phys, 1'b0);
        check("R1", "at-least vs zero ref, count 1", out_virt, 1'b1);

        // R10: reference change visible on second edge
        data_in = 32'd1; load_ref1 = 1; count_in = 1;
        step();
        check("R10", "first edge uses old ref", out_phys, 1'b0);
        load_ref1 = 0;
        step();
        check("R10", "second edge uses new ref", out_phys, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule